// File: doc/BRIEF.md
# Interrupt Pin Service and End-of-Interrupt Sequencer

This block sits between a set of raw interrupt lines and a destination resolver. For every line it works out an effective level from the line value and a per-line polarity bit. It keeps a pending bit for each line, and it decides when a line owes a delivery. Lines are either edge-triggered or level-triggered. A level-triggered line that has been delivered is blocked by its remote-IRR bit until an end-of-interrupt (EOI) tagged with its vector clears that bit. An EOI can also cause a second delivery when the line is still pending.

The per-line entries (polarity, trigger mode, mask, vector, destination, destination mode, delivery mode and remote IRR) live in an external table. The block reads them through flattened field inputs. It updates remote IRR only through one-cycle set and clear pulses. The table is expected to apply those pulses on the same clock edge at which they are asserted.

Deliveries leave on a valid/ready stream. Each delivery carries the line number and the line's fields, captured when the request is loaded. A request stays valid and unchanged until `req_ready` is seen high at a clock edge. While the stream is stalled, further deliveries collect as one owed bit per line. Two deliveries owed by the same line before it is loaded merge into one. EOIs arrive as a plain valid pulse and are never refused.

Top module: `irq_pin_sequencer`

## Requirements
- R1: The effective level of line i is `pin_level[i] ^ ent_polarity[i]`. Only a change of effective level counts as a line event, and the effective level before reset release is taken as 0. With polarity 1, a line that falls from 1 to 0 is a rising event.
- R2: A falling effective level clears the line's pending bit and delivers nothing. A later EOI for that line then causes no delivery.
- R3: An unmasked edge-triggered line (`ent_level_trig[i]`=0) that rises is delivered once. Its pending bit is cleared by that service.
- R4: A level-triggered line that rises is serviced only if its remote IRR, as presented on `ent_remote_irr`, is 0. Service of an unmasked level-triggered line asserts `rirr_set[i]` in the event cycle and owes one delivery.
- R5: A masked line (`ent_mask[i]`=1) is never delivered and never pulses `rirr_set`. For an edge-triggered line, service still clears the pending bit, so unmasking it later delivers nothing.
- R6: On `eoi_valid`, only the lowest-numbered line whose vector field equals `eoi_vector` is selected, and its `rirr_clr` bit pulses in that cycle. An EOI that matches no line pulses nothing and delivers nothing.
- R7: The selected line is delivered again if it is unmasked and its pending bit is set. This redelivery does not pulse `rirr_set`.
- R8: An EOI and a rising event on the same line in the same cycle are handled EOI first. A level-triggered line is then serviced even though its table remote IRR was 1: `rirr_set` pulses, `rirr_clr` stays 0, and one delivery is owed.
- R9: Owed deliveries are loaded one per cycle, lowest line number first. Two owed deliveries of one line that have not yet been loaded merge into one.
- R10: A delivery owed because of an event in the cycle ending at edge k is loaded at edge k+1 if the output is free. While `req_valid` is 1 and `req_ready` is 0, all request outputs hold.
- R11: During and right after reset, `req_valid` is 0 and nothing is owed or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NPINS | Raw interrupt line levels |
| ent_polarity | input | NPINS | Per-line polarity (1 inverts) |
| ent_level_trig | input | NPINS | Per-line trigger mode (1 level, 0 edge) |
| ent_mask | input | NPINS | Per-line mask |
| ent_vector | input | NPINS*VEC_W | Per-line vector, line i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | NPINS*DEST_W | Per-line destination, line i at bits [i*DEST_W +: DEST_W] |
| ent_dest_logical | input | NPINS | Per-line destination mode |
| ent_dlv_mode | input | NPINS*DLV_W | Per-line delivery mode, line i at bits [i*DLV_W +: DLV_W] |
| ent_remote_irr | input | NPINS | Remote IRR bits from the table |
| rirr_set | output | NPINS | Pulse: set remote IRR of the line |
| rirr_clr | output | NPINS | Pulse: clear remote IRR of the line |
| eoi_valid | input | 1 | EOI strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| req_valid | output | 1 | Delivery request valid |
| req_ready | input | 1 | Resolver accepts the request |
| req_pin | output | PIN_W | Line number of the request |
| req_vector | output | VEC_W | Vector of the request |
| req_dest | output | DEST_W | Destination of the request |
| req_dest_logical | output | 1 | Destination mode of the request |
| req_dlv_mode | output | DLV_W | Delivery mode of the request |

## Verification
The embedded properties hold on every cycle for a number of rules. A falling effective level leaves the pending bit clear. An edge-triggered line never keeps a pending bit after service. Masked lines never fire. A remote-IRR set pulse only comes with a level-triggered delivery. At most one line matches an EOI, at most one owed delivery is taken per cycle, and a stalled request holds. Some behaviours only show across the bench's scenarios: the ascending order of simultaneous lines, blocking until an EOI and the redelivery after it, lowest-match selection between lines that share a vector, the EOI-first rule, and the polarity inversion. The random run compares pulses and requests each cycle against a reference model, with back-pressure, mask and polarity changes mixed in.

// File: rtl/ioq_pkg.sv
package ioq_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_FALL = 2'd1,
    EV_RISE = 2'd2
  } lvl_event_e;

  function automatic lvl_event_e classify(input logic now_v, input logic was_v);
    if (now_v && !was_v) return EV_RISE;
    if (!now_v && was_v) return EV_FALL;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/ioq_pin_cell.sv
module ioq_pin_cell
  import ioq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic inv_pol,
  input  logic is_level,
  input  logic is_masked,
  input  logic rirr_now,
  input  logic eoi_hit,
  output logic fire,
  output logic set_rirr,
  output logic clr_rirr
);

  logic       eff;
  logic       prev_q;
  logic       irr_q;
  logic       irr_d;
  logic       rirr_seen;
  logic       svc;
  lvl_event_e ev;

  always_comb begin
    eff       = line_in ^ inv_pol;
    ev        = classify(eff, prev_q);
    // EOI is applied first: its clear is visible to a same-cycle event
    rirr_seen = rirr_now & ~eoi_hit;
    svc       = (ev == EV_RISE) && ((!is_level && !irr_q) || !rirr_seen);
    set_rirr  = svc & ~is_masked & is_level;
    fire      = (svc & ~is_masked) | (eoi_hit & ~is_masked & irr_q);
    clr_rirr  = eoi_hit & ~set_rirr;
    irr_d     = irr_q;
    case (ev)
      EV_FALL: irr_d = 1'b0;
      EV_RISE: irr_d = !(svc && !is_level);
      default: irr_d = irr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      irr_q  <= 1'b0;
    end else begin
      prev_q <= eff;
      irr_q  <= irr_d;
    end
  end

  assert_fall_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_FALL) |=> !irr_q);

  assert_edge_no_linger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev == EV_RISE) && !is_level && !irr_q) |=> !irr_q);

  assert_set_level_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_rirr |-> (is_level && !is_masked && fire));

  assert_masked_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_masked |-> !fire);

endmodule

// File: rtl/ioq_eoi_match.sv
module ioq_eoi_match #(
  parameter int NPINS = 8,
  parameter int VEC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eoi_valid,
  input  logic [VEC_W-1:0]         eoi_vector,
  input  logic [NPINS*VEC_W-1:0]   vec_flat,
  output logic [NPINS-1:0]         hit
);

  logic [NPINS-1:0] match;

  for (genvar i = 0; i < NPINS; i++) begin : g_cmp
    assign match[i] = eoi_valid && (vec_flat[i*VEC_W +: VEC_W] == eoi_vector);
    if (i == 0) begin : g_first
      assign hit[i] = match[i];
    end else begin : g_rest
      assign hit[i] = match[i] & ~(|match[i-1:0]);
    end
  end

  assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  assert_no_hit_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_valid |-> (hit == '0));

endmodule

// File: rtl/ioq_svc_arb.sv
module ioq_svc_arb #(
  parameter int NPINS  = 8,
  parameter int PIN_W  = 3,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  parameter int DLV_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          fire,
  input  logic [NPINS*VEC_W-1:0]    vec_flat,
  input  logic [NPINS*DEST_W-1:0]   dest_flat,
  input  logic [NPINS-1:0]          logical,
  input  logic [NPINS*DLV_W-1:0]    dlv_flat,
  input  logic                      req_ready,
  output logic                      req_valid,
  output logic [PIN_W-1:0]          req_pin,
  output logic [VEC_W-1:0]          req_vector,
  output logic [DEST_W-1:0]         req_dest,
  output logic                      req_dest_logical,
  output logic [DLV_W-1:0]          req_dlv_mode
);

  logic [NPINS-1:0] owed_q;
  logic [NPINS-1:0] take;
  logic [PIN_W-1:0] pick;
  logic             load;

  always_comb begin
    load = (|owed_q) && (!req_valid || req_ready);
    take = load ? (owed_q & (~owed_q + NPINS'(1))) : '0;
    pick = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (owed_q[i]) pick = PIN_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q           <= '0;
      req_valid        <= 1'b0;
      req_pin          <= '0;
      req_vector       <= '0;
      req_dest         <= '0;
      req_dest_logical <= 1'b0;
      req_dlv_mode     <= '0;
    end else begin
      owed_q <= (owed_q & ~take) | fire;
      if (load) begin
        req_valid        <= 1'b1;
        req_pin          <= pick;
        req_vector       <= vec_flat[pick*VEC_W +: VEC_W];
        req_dest         <= dest_flat[pick*DEST_W +: DEST_W];
        req_dest_logical <= logical[pick];
        req_dlv_mode     <= dlv_flat[pick*DLV_W +: DLV_W];
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_pin) && $stable(req_vector)
                                   && $stable(req_dest) && $stable(req_dlv_mode)
                                   && $stable(req_dest_logical)));

  assert_idle_after_reset_R11: assert property (@(posedge clk)
    !rst_n |=> !req_valid);

endmodule

// File: rtl/irq_pin_sequencer.sv
module irq_pin_sequencer #(
  parameter int NPINS  = 8,
  parameter int VEC_W  = 8,
  parameter int DEST_W = 8,
  parameter int DLV_W  = 3,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          pin_level,
  input  logic [NPINS-1:0]          ent_polarity,
  input  logic [NPINS-1:0]          ent_level_trig,
  input  logic [NPINS-1:0]          ent_mask,
  input  logic [NPINS*VEC_W-1:0]    ent_vector,
  input  logic [NPINS*DEST_W-1:0]   ent_dest,
  input  logic [NPINS-1:0]          ent_dest_logical,
  input  logic [NPINS*DLV_W-1:0]    ent_dlv_mode,
  input  logic [NPINS-1:0]          ent_remote_irr,
  output logic [NPINS-1:0]          rirr_set,
  output logic [NPINS-1:0]          rirr_clr,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [PIN_W-1:0]          req_pin,
  output logic [VEC_W-1:0]          req_vector,
  output logic [DEST_W-1:0]         req_dest,
  output logic                      req_dest_logical,
  output logic [DLV_W-1:0]          req_dlv_mode
);

  logic [NPINS-1:0] eoi_hit;
  logic [NPINS-1:0] fire;

  ioq_eoi_match #(.NPINS(NPINS), .VEC_W(VEC_W)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .vec_flat   (ent_vector),
    .hit        (eoi_hit)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    ioq_pin_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (pin_level[i]),
      .inv_pol   (ent_polarity[i]),
      .is_level  (ent_level_trig[i]),
      .is_masked (ent_mask[i]),
      .rirr_now  (ent_remote_irr[i]),
      .eoi_hit   (eoi_hit[i]),
      .fire      (fire[i]),
      .set_rirr  (rirr_set[i]),
      .clr_rirr  (rirr_clr[i])
    );
  end

  ioq_svc_arb #(
    .NPINS(NPINS), .PIN_W(PIN_W), .VEC_W(VEC_W), .DEST_W(DEST_W), .DLV_W(DLV_W)
  ) u_arb (
    .clk              (clk),
    .rst_n            (rst_n),
    .fire             (fire),
    .vec_flat         (ent_vector),
    .dest_flat        (ent_dest),
    .logical          (ent_dest_logical),
    .dlv_flat         (ent_dlv_mode),
    .req_ready        (req_ready),
    .req_valid        (req_valid),
    .req_pin          (req_pin),
    .req_vector       (req_vector),
    .req_dest         (req_dest),
    .req_dest_logical (req_dest_logical),
    .req_dlv_mode     (req_dlv_mode)
  );

  assert_pulse_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set & rirr_clr) == '0);

endmodule

// File: tb/sim_irq_pin_sequencer.sv
`timescale 1ns/1ps
module sim_irq_pin_sequencer;

  localparam int NP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NP-1:0]   lvl = '0, pol = '0, lt = '0, msk = '0, logi = '0, tbl = '0;
  logic [NP*8-1:0] vecf = '0, destf = '0;
  logic [NP*3-1:0] dlvf = '0;
  logic            eoi_v = 1'b0, rdy = 1'b0;
  logic [7:0]      eoi_vec = '0;

  logic [NP-1:0] rirr_set, rirr_clr;
  logic          req_valid, req_dest_logical;
  logic [2:0]    req_pin, req_dlv_mode;
  logic [7:0]    req_vector, req_dest;

  irq_pin_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .pin_level(lvl), .ent_polarity(pol),
    .ent_level_trig(lt), .ent_mask(msk), .ent_vector(vecf), .ent_dest(destf),
    .ent_dest_logical(logi), .ent_dlv_mode(dlvf), .ent_remote_irr(tbl),
    .rirr_set(rirr_set), .rirr_clr(rirr_clr), .eoi_valid(eoi_v), .eoi_vector(eoi_vec),
    .req_valid(req_valid), .req_ready(rdy), .req_pin(req_pin), .req_vector(req_vector),
    .req_dest(req_dest), .req_dest_logical(req_dest_logical), .req_dlv_mode(req_dlv_mode)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [NP-1:0] m_prev = '0, m_irr = '0, m_q = '0;
  logic          m_ov = 0, m_logi = 0;
  logic [2:0]    m_pin = '0, m_dlv = '0;
  logic [7:0]    m_vec = '0, m_dest = '0;
  logic [NP-1:0] e_set, e_clr, e_fire, e_irr, e_eff, s_set, s_clr;
  logic          e_load;
  int            e_lp;
  int            acc_log[0:4095];
  int            nlog = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(input logic [NP-1:0] v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic model_comb();
    logic [NP-1:0] hit;
    bit found;
    hit = '0; found = 0;
    e_eff = lvl ^ pol;
    for (int i = 0; i < NP; i++)
      if (!found && eoi_v && vecf[i*8 +: 8] == eoi_vec) begin hit[i] = 1; found = 1; end
    for (int i = 0; i < NP; i++) begin
      bit rise, fall, rs, svc;
      rise = e_eff[i] && !m_prev[i];
      fall = !e_eff[i] && m_prev[i];
      rs   = tbl[i] && !hit[i];
      svc  = rise && ((!lt[i] && !m_irr[i]) || !rs);
      e_set[i]  = svc && !msk[i] && lt[i];
      e_fire[i] = (svc && !msk[i]) || (hit[i] && !msk[i] && m_irr[i]);
      e_clr[i]  = hit[i] && !e_set[i];
      e_irr[i]  = fall ? 1'b0 : (rise ? !(svc && !lt[i]) : m_irr[i]);
    end
    e_load = (m_q != 0) && (!m_ov || rdy);
    e_lp   = lowest(m_q);
  endtask

  task automatic step();
    #2;
    model_comb();
    s_set = rirr_set; s_clr = rirr_clr;
    chk(rirr_set == e_set, "R4", "rirr_set", rirr_set, e_set);
    chk(rirr_clr == e_clr, "R6", "rirr_clr", rirr_clr, e_clr);
    chk(req_valid == m_ov, "R10", "req_valid", req_valid, m_ov);
    if (m_ov) begin
      chk(req_pin == m_pin, "R9", "req_pin", req_pin, m_pin);
      chk({req_vector, req_dest, req_dest_logical, req_dlv_mode} == {m_vec, m_dest, m_logi, m_dlv},
          "R10", "req fields", {req_vector, req_dest, req_dest_logical, req_dlv_mode},
          {m_vec, m_dest, m_logi, m_dlv});
    end
    if (req_valid && rdy && nlog < 4096) begin acc_log[nlog] = int'(req_pin); nlog++; end
    @(posedge clk); #1;
    if (e_load) begin
      m_ov = 1; m_pin = 3'(e_lp); m_vec = vecf[e_lp*8 +: 8]; m_dest = destf[e_lp*8 +: 8];
      m_logi = logi[e_lp]; m_dlv = dlvf[e_lp*3 +: 3];
      m_q[e_lp] = 1'b0;
    end else if (rdy) m_ov = 0;
    m_q = m_q | e_fire;
    m_prev = e_eff; m_irr = e_irr;
    tbl = (tbl & ~s_clr) | s_set;
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n0;
    int seed;
    seed = $urandom(32'h5EED1234);
    for (int i = 0; i < NP; i++) begin
      vecf[i*8 +: 8]  = 8'(8'h20 + i);
      destf[i*8 +: 8] = 8'(8'h10 + i);
      logi[i]         = i[0];
      dlvf[i*3 +: 3]  = 3'(i);
    end
    vecf[6*8 +: 8] = 8'h23;       // shares a vector with line 3
    lt = 8'b0101_1000;            // lines 3,4,6 level-triggered

    repeat (3) @(negedge clk);
    chk(req_valid == 0, "R11", "req_valid in reset", req_valid, 0);
    chk(rirr_set == 0 && rirr_clr == 0, "R11", "pulses in reset", {rirr_set, rirr_clr}, 0);
    rst_n = 1;
    step();
    chk(req_valid == 0, "R11", "req_valid after reset", req_valid, 0);

    // R9/R3: three edge lines at once, stalled, then drained in ascending order
    rdy = 0; lvl[2] = 1; lvl[5] = 1; lvl[7] = 1;
    steps(4);
    rdy = 1; steps(4);
    chk(nlog == 3, "R3", "single delivery per edge", nlog, 3);
    chk(acc_log[0] == 2 && acc_log[1] == 5 && acc_log[2] == 7, "R9", "order",
        {acc_log[0], acc_log[1], acc_log[2]}, {32'd2, 32'd5, 32'd7});
    lvl[2] = 0; lvl[5] = 0; lvl[7] = 0; step();

    // R4: level line blocked by remote IRR; R7: EOI redelivers
    lvl[4] = 1; step();
    chk(s_set[4] == 1, "R4", "rirr_set on level service", s_set[4], 1);
    steps(3); n0 = nlog;
    lvl[4] = 0; step(); lvl[4] = 1; step(); steps(3);
    chk(nlog == n0, "R4", "blocked while remote IRR", nlog, n0);
    eoi_v = 1; eoi_vec = 8'h24; step(); eoi_v = 0;
    chk(s_clr[4] == 1, "R6", "rirr_clr on EOI", s_clr[4], 1);
    steps(3);
    chk(nlog == n0 + 1 && acc_log[nlog-1] == 4, "R7", "EOI redelivery", nlog, n0 + 1);

    // R2: fall then EOI gives nothing
    lvl[4] = 0; step(); n0 = nlog;
    eoi_v = 1; eoi_vec = 8'h24; step(); eoi_v = 0; steps(3);
    chk(nlog == n0, "R2", "no delivery after fall", nlog, n0);

    // R6: duplicate vector picks the lowest line; unmatched vector ignored
    eoi_v = 1; eoi_vec = 8'h23; step(); eoi_v = 0;
    chk(s_clr == 8'h08, "R6", "lowest match", s_clr, 8'h08);
    eoi_v = 1; eoi_vec = 8'h99; step(); eoi_v = 0;
    chk(s_clr == 8'h00, "R6", "no match", s_clr, 0);
    steps(3);
    chk(nlog == n0, "R6", "no delivery from EOIs", nlog, n0);

    // R5: masked edge line, then unmasked without a new event
    msk[1] = 1; lvl[1] = 1; step(); steps(3);
    chk(nlog == n0, "R5", "masked line silent", nlog, n0);
    msk[1] = 0; steps(3);
    chk(nlog == n0, "R5", "unmask delivers nothing", nlog, n0);
    lvl[1] = 0; step();

    // R1: inverted polarity, falling line is the rising event
    pol[0] = 1; lvl[0] = 1; step(); steps(3);
    chk(nlog == n0, "R1", "no event with eff level 0", nlog, n0);
    lvl[0] = 0; step(); steps(3);
    chk(nlog == n0 + 1 && acc_log[nlog-1] == 0, "R1", "inverted rise delivers", nlog, n0 + 1);
    pol[0] = 0; step();

    // R8: EOI and rise of the same level line in one cycle
    lvl[3] = 1; step(); steps(3);
    lvl[3] = 0; step(); n0 = nlog;
    chk(tbl[3] == 1, "R8", "remote IRR set before test", tbl[3], 1);
    lvl[3] = 1; eoi_v = 1; eoi_vec = 8'h23; step(); eoi_v = 0;
    chk(s_set[3] == 1 && s_clr[3] == 0, "R8", "EOI first pulses", {s_set[3], s_clr[3]}, 2'b10);
    steps(3);
    chk(nlog == n0 + 1 && acc_log[nlog-1] == 3, "R8", "delivery after EOI first", nlog, n0 + 1);

    // random phase
    for (int c = 0; c < 3000; c++) begin
      lvl = 8'($urandom);
      eoi_v = ($urandom % 4) == 0;
      eoi_vec = 8'(8'h20 + ($urandom % 10));
      rdy = ($urandom % 3) != 0;
      if (($urandom % 32) == 0) msk = 8'($urandom);
      if (($urandom % 32) == 0) pol = 8'($urandom);
      step();
    end
    eoi_v = 0; rdy = 1; steps(20);
    chk(req_valid == 0 && m_q == 0, "R9", "drained", req_valid, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule